// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the host side of a link to a serial successive-approximation converter. The link has four wires and one status line: an active-low select, a serial clock, a command line toward the converter, a result line back from it, and a busy flag. A single request pulse with a channel number, a single-ended/differential choice and a power mode makes the controller run one complete conversion frame. The result is then returned on a parallel bus with a one-cycle strobe.

A frame is always 24 serial clocks long. During the first 8 clocks an 8-bit command goes out. The converter flags busy for one clock after it. The controller then shifts in a 16-bit result. The serial clock comes from the system clock through a divider set by a parameter. Between frames the select line stays high for a guard interval and the command line is held low. This matters because the converter treats the first high bit it sees as the start of a command. A request that carries the reserved power code is refused with an error strobe and no frame is run.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset `adc_cs_n` is 1, `adc_sclk` is 0, `adc_mosi` is 0, `ready` is 1 and `valid` is 0.
- R2: The command byte goes out MSB first and is valid at each of the first 8 rising serial edges. Its layout is: bit 7 = 1, bits 6..4 = `channel`, bit 3 = 0, bit 2 = `single_ended`, bits 1..0 = `pwr_mode`. `adc_mosi` never changes while `adc_sclk` is high.
- R3: Every accepted request gives exactly 24 rising serial edges with `adc_cs_n` low for the whole frame. Each high phase of `adc_sclk` lasts HALF_DIV system cycles, and `adc_sclk` is low whenever `adc_cs_n` is high.
- R4: `adc_mosi` is 0 whenever `adc_cs_n` is high and after the 8th command bit has been sent.
- R5: `adc_miso` is sampled on rising edges 9 through 24. The first sample is result bit 15 and the last is bit 0. `result` is updated and `valid` pulses for one cycle in the same cycle that `adc_cs_n` returns high.
- R6: With CHECK_BUSY=1, `adc_busy` is sampled at rising edge 9. `busy_timeout` pulses together with `valid` exactly when that sample was 0. With a correct busy pulse it stays 0.
- R7: A request with `pwr_mode` = 2'b01 (the reserved code) pulses `req_err` for one cycle. It starts no frame (`adc_cs_n` stays 1) and leaves `ready` at 1. Codes 00 (sleep between frames), 10 (converter-timed) and 11 (always on) are all sent unchanged.
- R8: A `start` pulse while `ready` is 0 has no effect: no extra frame, no change to the frame in progress.
- R9: After a frame, `adc_cs_n` stays high for at least 2*HALF_DIV system cycles before the next frame, and `ready` is 0 until then.
- R10: The first frame after a frame in sleep mode (code 00) returns its result like any other frame. No frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion frame |
| channel | input | CH_W | Converter input channel |
| single_ended | input | 1 | 1 = single-ended, 0 = differential |
| pwr_mode | input | 2 | Power mode code sent in bits 1..0 |
| ready | output | 1 | Controller idle and accepting requests |
| result | output | RES_W | Last captured conversion result |
| valid | output | 1 | One-cycle strobe: `result` updated |
| req_err | output | 1 | One-cycle strobe: reserved power code refused |
| busy_timeout | output | 1 | Strobe with `valid` when no busy pulse was seen |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_mosi | output | 1 | Command data to converter |
| adc_miso | input | 1 | Result data from converter |
| adc_busy | input | 1 | Converter busy flag |

## Verification
The bench builds the controller with HALF_DIV=2, CHECK_BUSY=1 and the default 3-bit channel and 16-bit result. The short divider keeps each 24-clock frame to about 100 system cycles, so back-to-back frames, the guard gap and a request arriving mid-frame all fit in a brief run. Because CHECK_BUSY is enabled, a converter model that leaves busy low exercises the timeout strobe. The model clocks in the command, returns known 16-bit patterns (all ones, alternating, single-bit) and can suppress its busy pulse.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
   localparam int CMD_BITS   = 8;
   localparam int RES_BITS   = 16;
   localparam int FRAME_CLKS = 24;

   typedef enum logic [1:0] {
      PM_SLEEP    = 2'b00,
      PM_RESERVED = 2'b01,
      PM_CONV_CLK = 2'b10,
      PM_AWAKE    = 2'b11
   } pwr_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FRAME,
      ST_GAP
   } seq_state_e;
endpackage

// File: rtl/adc_cmd_pack.sv
module adc_cmd_pack
   import adc_frame_pkg::*;
#(
   parameter int CH_W = 3
) (
   input  logic [CH_W-1:0]     channel,
   input  logic                single_ended,
   input  logic [1:0]          pwr_mode,
   output logic [CMD_BITS-1:0] cmd_byte,
   output logic                reserved
);
   pwr_mode_e mode;

   always_comb begin
      mode     = pwr_mode_e'(pwr_mode);
      reserved = (mode == PM_RESERVED);
      cmd_byte = {1'b1, channel, 1'b0, single_ended, pwr_mode};
   end
endmodule

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int DW = $clog2(HALF_DIV);
         logic [DW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         cnt <= '0;
            else if (!run)                      cnt <= '0;
            else if (cnt == DW'(HALF_DIV - 1))  cnt <= '0;
            else                                cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == DW'(HALF_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
   import adc_frame_pkg::*;
#(
   parameter int GAP_CYC    = 8,
   parameter bit CHECK_BUSY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [CMD_BITS-1:0] cmd_byte,
   input  logic                reserved,
   input  logic                tick,
   input  logic                miso,
   input  logic                busy,
   output logic                run,
   output logic                cs_n,
   output logic                sclk,
   output logic                mosi,
   output logic                ready,
   output logic [RES_BITS-1:0] result,
   output logic                valid,
   output logic                req_err,
   output logic                busy_timeout
);
   localparam int EDGES     = 2 * FRAME_CLKS;
   localparam int HW        = $clog2(EDGES);
   localparam int GW        = $clog2(GAP_CYC + 1);
   localparam int LAST_EDGE = EDGES - 1;
   localparam int FIRST_CAP = 2 * CMD_BITS;

   seq_state_e          state;
   logic [HW-1:0]       edge_idx;
   logic [GW-1:0]       gap_cnt;
   logic [CMD_BITS-1:0] shreg;
   logic [RES_BITS-1:0] cap;
   logic                accept;
   logic                rise_tick;
   logic                fall_tick;
   logic                frame_end;
   logic                cap_busy;

   assign run       = (state == ST_FRAME);
   assign ready     = (state == ST_IDLE);
   assign accept    = ready && start && !reserved;
   assign rise_tick = run && tick && !sclk;
   assign fall_tick = run && tick && sclk;
   assign frame_end = fall_tick && (edge_idx == HW'(LAST_EDGE));
   assign cap_busy  = rise_tick && (edge_idx == HW'(FIRST_CAP));
   assign mosi      = !cs_n && shreg[CMD_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         edge_idx <= '0;
         gap_cnt  <= '0;
         shreg    <= '0;
         cap      <= '0;
         result   <= '0;
         cs_n     <= 1'b1;
         sclk     <= 1'b0;
         valid    <= 1'b0;
         req_err  <= 1'b0;
      end else begin
         valid   <= 1'b0;
         req_err <= ready && start && reserved;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state    <= ST_FRAME;
                  cs_n     <= 1'b0;
                  shreg    <= cmd_byte;
                  edge_idx <= '0;
               end
            end
            ST_FRAME: begin
               if (tick) begin
                  sclk     <= !sclk;
                  edge_idx <= edge_idx + 1'b1;
                  if (rise_tick && edge_idx >= HW'(FIRST_CAP))
                     cap <= {cap[RES_BITS-2:0], miso};
                  if (fall_tick)
                     shreg <= {shreg[CMD_BITS-2:0], 1'b0};
                  if (frame_end) begin
                     state   <= ST_GAP;
                     cs_n    <= 1'b1;
                     valid   <= 1'b1;
                     result  <= cap;
                     gap_cnt <= '0;
                  end
               end
            end
            ST_GAP: begin
               if (gap_cnt == GW'(GAP_CYC - 1)) state <= ST_IDLE;
               gap_cnt <= gap_cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   generate
      if (CHECK_BUSY) begin : g_busy_watch
         logic busy_seen;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_seen    <= 1'b0;
               busy_timeout <= 1'b0;
            end else begin
               if (accept)        busy_seen <= 1'b0;
               else if (cap_busy) busy_seen <= busy;
               busy_timeout <= frame_end && !busy_seen;
            end
         end
      end else begin : g_busy_off
         logic unused_busy;
         assign unused_busy  = busy ^ cap_busy;
         assign busy_timeout = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
   import adc_frame_pkg::*;
#(
   parameter int CH_W       = 3,
   parameter int RES_W      = 16,
   parameter int HALF_DIV   = 4,
   parameter bit CHECK_BUSY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CH_W-1:0]  channel,
   input  logic             single_ended,
   input  logic [1:0]       pwr_mode,
   output logic             ready,
   output logic [RES_W-1:0] result,
   output logic             valid,
   output logic             req_err,
   output logic             busy_timeout,
   output logic             adc_cs_n,
   output logic             adc_sclk,
   output logic             adc_mosi,
   input  logic             adc_miso,
   input  logic             adc_busy
);
   localparam int GAP_CYC = 2 * HALF_DIV;

   if (CH_W != 3) begin : g_bad_ch
      $error("CH_W must be 3 to fill the channel field of the command byte");
   end
   if (RES_W != RES_BITS) begin : g_bad_res
      $error("RES_W must equal the 16-bit result length of the frame");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   logic [CMD_BITS-1:0] cmd_byte;
   logic                reserved;
   logic                run;
   logic                tick;
   logic [RES_BITS-1:0] res_int;

   adc_cmd_pack #(.CH_W(CH_W)) u_pack (
      .channel      (channel),
      .single_ended (single_ended),
      .pwr_mode     (pwr_mode),
      .cmd_byte     (cmd_byte),
      .reserved     (reserved)
   );

   adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   adc_frame_seq #(.GAP_CYC(GAP_CYC), .CHECK_BUSY(CHECK_BUSY)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .cmd_byte     (cmd_byte),
      .reserved     (reserved),
      .tick         (tick),
      .miso         (adc_miso),
      .busy         (adc_busy),
      .run          (run),
      .cs_n         (adc_cs_n),
      .sclk         (adc_sclk),
      .mosi         (adc_mosi),
      .ready        (ready),
      .result       (res_int),
      .valid        (valid),
      .req_err      (req_err),
      .busy_timeout (busy_timeout)
   );

   assign result = RES_W'(res_int);
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic adc_cs_n,
   input logic adc_sclk,
   input logic adc_mosi,
   input logic ready,
   input logic valid,
   input logic req_err,
   input logic busy_timeout
);
   AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> !adc_mosi); // R4
   AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> !adc_sclk); // R3
   AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_sclk && $past(adc_sclk)) |-> $stable(adc_mosi)); // R2
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R5
   AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $rose(adc_cs_n)); // R5
   AST_TIMEOUT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      busy_timeout |-> valid); // R6
   AST_REFUSE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> adc_cs_n); // R7
   AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> adc_cs_n); // R9
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .adc_cs_n     (adc_cs_n),
   .adc_sclk     (adc_sclk),
   .adc_mosi     (adc_mosi),
   .ready        (ready),
   .valid        (valid),
   .req_err      (req_err),
   .busy_timeout (busy_timeout)
);

// File: tb/adc_frame_ctrl_tb.sv
`timescale 1ns/1ps
module adc_frame_ctrl_tb;
   localparam int HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  channel = '0;
   logic        single_ended = 1'b0;
   logic [1:0]  pwr_mode = 2'b11;
   logic        ready, valid, req_err, busy_timeout;
   logic [15:0] result;
   logic        adc_cs_n, adc_sclk, adc_mosi;
   logic        adc_miso = 1'b0;
   logic        adc_busy = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   adc_frame_ctrl #(.CH_W(3), .RES_W(16), .HALF_DIV(HALF), .CHECK_BUSY(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .channel(channel),
      .single_ended(single_ended), .pwr_mode(pwr_mode), .ready(ready),
      .result(result), .valid(valid), .req_err(req_err),
      .busy_timeout(busy_timeout), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
      .adc_mosi(adc_mosi), .adc_miso(adc_miso), .adc_busy(adc_busy)
   );

   // converter model
   int          m_rise = 0;
   int          frames = 0;
   logic [7:0]  m_cmd = '0;
   logic [15:0] m_val = '0;
   bit          m_busy_en = 1'b1;

   always @(negedge adc_cs_n) begin
      m_rise   = 0;
      adc_miso = 1'b0;
      adc_busy = 1'b0;
      frames++;
   end

   always @(posedge adc_sclk) begin
      if (!adc_cs_n) begin
         m_rise++;
         if (m_rise <= 8) m_cmd = {m_cmd[6:0], adc_mosi};
      end
   end

   always @(negedge adc_sclk) begin
      if (!adc_cs_n) begin
         if (m_rise == 8) begin
            adc_busy = m_busy_en;
            adc_miso = m_val[15];
         end else if (m_rise == 9) begin
            adc_busy = 1'b0;
            adc_miso = m_val[14];
         end else if (m_rise >= 10 && m_rise <= 23) begin
            adc_miso = m_val[23 - m_rise];
         end else begin
            adc_miso = 1'b0;
         end
      end
   end

   // line monitors
   int   hi_run = 0;
   int   bad_high = 0;
   int   mosi_idle_bad = 0;
   int   mosi_tail_bad = 0;
   int   cs_hi = 0;
   int   last_gap = 0;
   logic prev_sclk = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (adc_sclk) hi_run++;
         else begin
            if (prev_sclk && hi_run != HALF) bad_high++;
            hi_run = 0;
         end
         prev_sclk = adc_sclk;
         if (adc_cs_n && adc_mosi) mosi_idle_bad++;
         if (!adc_cs_n && m_rise >= 8 && !(m_rise == 8 && adc_sclk) && adc_mosi)
            mosi_tail_bad++;
         if (adc_cs_n) cs_hi++;
         else begin
            if (cs_hi != 0) last_gap = cs_hi;
            cs_hi = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start(input logic [2:0] ch, input logic se, input logic [1:0] pm);
      @(negedge clk);
      channel = ch; single_ended = se; pwr_mode = pm; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_valid(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (valid) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic run_frame(input logic [2:0] ch, input logic se, input logic [1:0] pm,
                            input logic [15:0] val, input bit busy_en, input string tag);
      bit seen;
      logic [7:0] exp_cmd;
      exp_cmd = {1'b1, ch, 1'b0, se, pm};
      m_val = val; m_busy_en = busy_en;
      wait (ready);
      pulse_start(ch, se, pm);
      wait_valid(seen);
      chk(seen, {tag, " valid"}, int'(seen), 1);
      chk(result == val, {tag, " R5 result"}, int'(result), int'(val));
      chk(m_cmd == exp_cmd, "R2 command byte", int'(m_cmd), int'(exp_cmd));
      chk(m_rise == 24, "R3 rising edges", m_rise, 24);
      chk(busy_timeout == !busy_en, "R6 busy_timeout", int'(busy_timeout), int'(!busy_en));
      chk(adc_cs_n == 1'b1, "R5 cs released with valid", int'(adc_cs_n), 1);
      @(negedge clk);
      chk(valid == 1'b0, "R5 valid single cycle", int'(valid), 0);
   endtask

   task automatic t_reset;
      chk(adc_cs_n == 1'b1, "R1 cs_n", int'(adc_cs_n), 1);
      chk(adc_sclk == 1'b0, "R1 sclk", int'(adc_sclk), 0);
      chk(adc_mosi == 1'b0, "R1 mosi", int'(adc_mosi), 0);
      chk(ready == 1'b1, "R1 ready", int'(ready), 1);
      chk(valid == 1'b0, "R1 valid", int'(valid), 0);
   endtask

   task automatic t_reserved;
      int f0;
      f0 = frames;
      wait (ready);
      pulse_start(3'd5, 1'b1, 2'b01);
      chk(req_err == 1'b1, "R7 req_err", int'(req_err), 1);
      chk(ready == 1'b1, "R7 ready kept", int'(ready), 1);
      @(negedge clk);
      chk(req_err == 1'b0, "R7 req_err pulse", int'(req_err), 0);
      repeat (20) @(negedge clk);
      chk(frames == f0, "R7 no frame", frames, f0);
      chk(adc_cs_n == 1'b1, "R7 cs_n idle", int'(adc_cs_n), 1);
   endtask

   task automatic t_ignore;
      int  f0;
      bit  seen;
      f0 = frames;
      m_val = 16'h1234; m_busy_en = 1'b1;
      wait (ready);
      pulse_start(3'd2, 1'b0, 2'b11);
      repeat (10) @(negedge clk);
      chk(ready == 1'b0, "R8 ready low in frame", int'(ready), 0);
      pulse_start(3'd7, 1'b1, 2'b00);
      wait_valid(seen);
      chk(seen && result == 16'h1234, "R8 result unchanged", int'(result), 'h1234);
      chk(m_cmd == 8'hA3, "R8 command unchanged", int'(m_cmd), 'hA3);
      repeat (30) @(negedge clk);
      chk(frames == f0 + 1, "R8 no extra frame", frames, f0 + 1);
   endtask

   task automatic t_gap;
      run_frame(3'd3, 1'b1, 2'b11, 16'h0F0F, 1'b1, "R9 first");
      chk(ready == 1'b0, "R9 ready low in gap", int'(ready), 0);
      run_frame(3'd4, 1'b0, 2'b11, 16'hF0F0, 1'b1, "R9 second");
      chk(last_gap >= 2 * HALF, "R9 gap length", last_gap, 2 * HALF);
   endtask

   bit done = 1'b0;
   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      run_frame(3'd0, 1'b0, 2'b11, 16'hFFFF, 1'b1, "R2 all ones");
      run_frame(3'd5, 1'b1, 2'b10, 16'hA5C3, 1'b1, "R5 pattern");
      run_frame(3'd6, 1'b1, 2'b00, 16'h0001, 1'b1, "R10 sleep");
      run_frame(3'd1, 1'b0, 2'b11, 16'h8000, 1'b1, "R10 after sleep");
      run_frame(3'd7, 1'b0, 2'b11, 16'h5AA5, 1'b0, "R6 no busy");
      t_reserved;
      t_ignore;
      t_gap;
      chk(bad_high == 0, "R3 sclk high phase", bad_high, 0);
      chk(mosi_idle_bad == 0, "R4 mosi while deselected", mosi_idle_bad, 0);
      chk(mosi_tail_bad == 0, "R4 mosi after command", mosi_tail_bad, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule